// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Ordering Stall

This block sits beside the local line-state array of one core. Incoming invalidation requests from the coherence side are accepted and acknowledged in the same cycle they arrive, as long as a slot is free. The line index is parked in a small FIFO, and the valid bit of that line is cleared only later. Because the sender gets its acknowledgment at once, it does not wait for the local array. The cost is that a load to a line whose invalidation is still queued may report a stale hit.

The local array has one lookup port. The queue drains one entry per cycle, oldest first, in any cycle where that port is not taken by a granted load. A load-fence strobe makes the block stall loads until every invalidation that was queued before the fence has been applied. While the stall is active, the drain has priority. Invalidations that arrive during or after the fence cycle do not extend the stall. A fill strobe marks a line present. Stores never reach this block.

Top module: `inval_queue`

## Requirements
- R1: An invalidation request is acknowledged in the same cycle it is presented (`invAck` high, combinationally) whenever the queue holds fewer than DEPTH entries, and an entry is allocated at that clock edge. `invAck` is never high without `invValid`.
- R2: With DEPTH entries held, `invAck` stays low and the request allocates nothing and has no effect on line state.
- R3: Queued invalidations are applied at most one per cycle, oldest first. Applying an entry clears the valid bit of its line, so a later load to that line reports a miss.
- R4: An entry is applied only in a cycle with no `ldValid`, or while `ldStall` is high. While loads are presented every cycle, a line with a pending invalidation still reports a hit (stale).
- R5: If `fenceReq` is pulsed while k entries are held, `ldStall` is high for exactly k cycles, starting in the fence cycle. `ldHit` is low while `ldStall` is high. Afterwards, loads to every line named by those k entries miss.
- R6: An invalidation accepted in the fence cycle or later does not lengthen the stall. Its line keeps hitting until that entry is drained.
- R7: `fillValid` sets the valid bit of `fillLine` at the next edge. If that line's invalidation is applied in the same cycle, the fill wins.
- R8: After reset, all lines are invalid, the queue is empty and `ldStall` is low.
- R9: `qEmpty` is high exactly when no invalidation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| invValid | input | 1 | Invalidation request present |
| invLine | input | log2(LINES) | Line index to invalidate |
| invAck | output | 1 | Request accepted this cycle |
| fillValid | input | 1 | Mark a line present |
| fillLine | input | log2(LINES) | Line index to mark present |
| ldValid | input | 1 | Load lookup presented |
| ldLine | input | log2(LINES) | Line index looked up |
| ldHit | output | 1 | Granted load found the line valid |
| ldStall | output | 1 | Load held back by a fence |
| fenceReq | input | 1 | Load-fence pulse |
| qEmpty | output | 1 | No invalidation held |

## Verification
The bound checker watches properties that must hold on every cycle:
- no acknowledgment without a request, and none at full occupancy;
- occupancy never above DEPTH;
- no hit while stalled;
- no stall with an empty queue;
- one drained entry per stalled cycle.

Only the bench scenarios can show the following:
- stale hits while loads hold the array port;
- the exact stall length for each occupancy from zero to full;
- that a late invalidation survives the fence;
- oldest-first drain order;
- fill taking precedence over a same-cycle clear.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;   // allocate the presented invalidation
    logic pop;    // apply and retire the oldest entry
  } iqStrobes_t;
endpackage

// File: rtl/iq_ctrl.sv
module iq_ctrl #(
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             invValid,
  input  logic             ldValid,
  input  logic             fenceReq,
  output iq_pkg::iqStrobes_t strobes,
  output logic             invAck,
  output logic             ldStall,
  output logic             qEmpty,
  output logic [CNTW-1:0]  occ
);
  localparam logic [CNTW-1:0] FULLV = CNTW'(DEPTH);

  logic [CNTW-1:0] fenceCnt;
  logic full;
  logic push;
  logic pop;

  assign full    = (occ == FULLV);
  assign push    = invValid && !full;
  assign ldStall = (fenceReq && (occ != '0)) || (fenceCnt != '0);
  assign pop     = (occ != '0) && (!ldValid || ldStall);

  assign invAck       = push;
  assign qEmpty       = (occ == '0);
  assign strobes.push = push;
  assign strobes.pop  = pop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ      <= '0;
      fenceCnt <= '0;
    end else begin
      occ <= occ + CNTW'(push) - CNTW'(pop);
      if (fenceReq)
        fenceCnt <= occ - CNTW'(pop);
      else if (fenceCnt != '0)
        fenceCnt <= fenceCnt - CNTW'(pop);
    end
  end
endmodule

// File: rtl/iq_data.sv
module iq_data #(
  parameter int LINES = 16,
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  iq_pkg::iqStrobes_t strobes,
  input  logic [IDXW-1:0]   invLine,
  input  logic              fillValid,
  input  logic [IDXW-1:0]   fillLine,
  input  logic              ldValid,
  input  logic              ldStall,
  input  logic [IDXW-1:0]   ldLine,
  output logic              ldHit
);
  localparam logic [PTRW-1:0] LASTP = PTRW'(DEPTH - 1);

  logic [IDXW-1:0] slots [DEPTH];
  logic [PTRW-1:0] wrPtr;
  logic [PTRW-1:0] rdPtr;
  logic [IDXW-1:0] headLine;
  logic [LINES-1:0] validBits;

  assign headLine = slots[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == LASTP) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)
        rdPtr <= (rdPtr == LASTP) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push)
      slots[wrPtr] <= invLine;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic clrHere;
    logic setHere;
    assign clrHere = strobes.pop && (headLine == IDXW'(g));
    assign setHere = fillValid && (fillLine == IDXW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        validBits[g] <= 1'b0;
      else if (setHere)
        validBits[g] <= 1'b1;
      else if (clrHere)
        validBits[g] <= 1'b0;
    end
  end

  assign ldHit = ldValid && !ldStall && validBits[ldLine];
endmodule

// File: rtl/inval_queue.sv
module inval_queue #(
  parameter int LINES = 16,
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            invValid,
  input  logic [IDXW-1:0] invLine,
  output logic            invAck,
  input  logic            fillValid,
  input  logic [IDXW-1:0] fillLine,
  input  logic            ldValid,
  input  logic [IDXW-1:0] ldLine,
  output logic            ldHit,
  output logic            ldStall,
  input  logic            fenceReq,
  output logic            qEmpty
);
  iq_pkg::iqStrobes_t strobes;
  logic [CNTW-1:0] occ;

  iq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .invValid(invValid), .ldValid(ldValid),
    .fenceReq(fenceReq), .strobes(strobes), .invAck(invAck),
    .ldStall(ldStall), .qEmpty(qEmpty), .occ(occ)
  );

  iq_data #(.LINES(LINES), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .invLine(invLine),
    .fillValid(fillValid), .fillLine(fillLine), .ldValid(ldValid),
    .ldStall(ldStall), .ldLine(ldLine), .ldHit(ldHit)
  );
endmodule

// File: rtl/inval_queue_chk.sv
module inval_queue_chk #(
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            invValid,
  input logic            invAck,
  input logic            ldHit,
  input logic            ldStall,
  input logic            qEmpty,
  input logic [CNTW-1:0] occ
);
  // R1
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    invAck |-> invValid);
  // R2
  no_ack_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNTW'(DEPTH)) |-> !invAck);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNTW'(DEPTH));
  // R5
  no_hit_in_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldStall |-> !ldHit);
  // R5
  no_stall_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    qEmpty |-> !ldStall);
  // R3
  drain_one_per_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldStall && !invAck) |=> (occ == $past(occ) - 1'b1));
  // R9
  empty_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qEmpty && !invAck) |=> qEmpty);
endmodule

bind inval_queue inval_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .invValid(invValid), .invAck(invAck),
  .ldHit(ldHit), .ldStall(ldStall), .qEmpty(qEmpty), .occ(occ)
);

// File: tb/inval_queue_tb.sv
`timescale 1ns/1ps
module inval_queue_tb;
  localparam int LINES = 16;
  localparam int DEPTH = 4;
  localparam int IDXW = $clog2(LINES);

  logic clk = 1'b0;
  logic rstN;
  logic invValid, invAck, fillValid, ldValid, ldHit, ldStall, fenceReq, qEmpty;
  logic [IDXW-1:0] invLine, fillLine, ldLine;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  inval_queue #(.LINES(LINES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .invValid(invValid), .invLine(invLine),
    .invAck(invAck), .fillValid(fillValid), .fillLine(fillLine),
    .ldValid(ldValid), .ldLine(ldLine), .ldHit(ldHit), .ldStall(ldStall),
    .fenceReq(fenceReq), .qEmpty(qEmpty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  initial begin
    int stallCnt;
    rstN = 0; invValid = 0; invLine = '0; fillValid = 0; fillLine = '0;
    ldValid = 0; ldLine = '0; fenceReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R8 empty", qEmpty, 1);
    chk("R8 stall", ldStall, 0);
    @(negedge clk);
    // R8: every line invalid after reset
    for (int l = 0; l < LINES; l++) begin
      ldValid = 1; ldLine = IDXW'(l);
      #1 chk("R8 miss", ldHit, 0);
      @(negedge clk);
    end

    for (int k = 0; k <= DEPTH; k++) begin
      ldValid = 0;
      for (int l = 0; l < LINES; l++) begin
        fillValid = 1; fillLine = IDXW'(l);
        @(negedge clk);
      end
      fillValid = 0;
      repeat (DEPTH) @(negedge clk);
      #1 chk("R9 empty", qEmpty, 1);
      // R7: filled line reports a hit
      ldValid = 1; ldLine = 4'd15;
      #1 chk("R7 fill", ldHit, 1);
      @(negedge clk);
      for (int i = 0; i < k; i++) begin
        invValid = 1; invLine = IDXW'(i * 3);
        #1 chk("R1 ack", invAck, 1);
        @(negedge clk);
      end
      if (k == DEPTH) begin
        invValid = 1; invLine = 4'd14;
        #1 chk("R2 full no ack", invAck, 0);
        @(negedge clk);
      end
      invValid = 0;
      #1 chk("R9 occupancy", qEmpty, (k == 0) ? 1 : 0);
      @(negedge clk);
      for (int i = 0; i < k; i++) begin
        ldLine = IDXW'(i * 3);
        #1 chk("R4 stale hit", ldHit, 1);
        @(negedge clk);
      end
      // fence, with a late invalidation in the same cycle when room exists
      ldLine = 4'd15; fenceReq = 1;
      if (k < DEPTH) begin invValid = 1; invLine = 4'd13; end
      #1;
      stallCnt = ldStall ? 1 : 0;
      chk("R5 hit gated", ldHit, (k == 0) ? 1 : 0);
      @(negedge clk);
      fenceReq = 0; invValid = 0;
      for (int w = 0; w < 12; w++) begin
        #1;
        if (!ldStall) break;
        stallCnt++;
        @(negedge clk);
      end
      chk("R5 stall length", stallCnt, k);
      for (int i = 0; i < k; i++) begin
        ldLine = IDXW'(i * 3);
        #1 chk("R5 applied miss", ldHit, 0);
        @(negedge clk);
      end
      if (k < DEPTH) begin
        ldLine = 4'd13;
        #1 chk("R6 late stays", ldHit, 1);
        chk("R6 late queued", qEmpty, 0);
      end else begin
        ldLine = 4'd14;
        #1 chk("R2 rejected no effect", ldHit, 1);
      end
      @(negedge clk);
      ldValid = 0;
      @(negedge clk);
      ldValid = 1; ldLine = 4'd13;
      #1 chk("R3 background drain", ldHit, (k < DEPTH) ? 0 : 1);
      chk("R9 drained", qEmpty, 1);
      @(negedge clk);
    end

    // R3 order: two entries, one idle cycle applies only the oldest
    ldValid = 1; ldLine = 4'd15;
    invValid = 1; invLine = 4'd2; @(negedge clk);
    invLine = 4'd4; @(negedge clk);
    invValid = 0; ldValid = 0; @(negedge clk);
    ldValid = 1; ldLine = 4'd2;
    #1 chk("R3 oldest applied", ldHit, 0);
    @(negedge clk);
    ldLine = 4'd4;
    #1 chk("R3 one per cycle", ldHit, 1);
    @(negedge clk);
    // R7: fill wins over same-cycle apply of line 4
    ldValid = 0; fillValid = 1; fillLine = 4'd4; @(negedge clk);
    fillValid = 0; ldValid = 1; ldLine = 4'd4;
    #1 chk("R7 fill wins", ldHit, 1);
    chk("R9 empty after", qEmpty, 1);
    @(negedge clk);
    finish_run();
  end
endmodule